// File: doc/BRIEF.md
# Serial Sample Streamer for a Slow Converter

This block feeds 8-bit samples from a small queue to an external serial digital-to-analog converter. A host writes samples through a simple write port on the fast system clock (around 33 MHz). The converter's bit clock (around 425 kHz) is asynchronous to it. That slow clock is only sampled as data: it passes through a three-flop synchroniser, and its rising edge becomes a one-cycle tick. Every register in the block therefore shares the fast clock.

On each tick the block presents one sample bit on the serial line. It starts with the most significant bit. When a sample has been fully sent, the next tick takes a new sample from the queue, and a word strobe marks the first bit of each sample. If the queue is empty at that moment, the last sample is sent again and a sticky underrun flag is raised. Because the tick comes from a synchronised copy of the slow clock, serial transitions land two to three fast cycles after each slow rising edge, with up to one fast period of jitter. The converter captures on the slow falling edge, so it sees settled data.

Top module: `dac_stream_driver`

## Requirements
- R1: After a synchronous reset, fifoEmpty=1, fifoFull=0, serOut=0, wordStrobe=0 and underrun=0.
- R2: The queue holds 16 samples. fifoEmpty drops after the first accepted write, and fifoFull rises once 16 samples are stored and none has been taken.
- R3: A write while fifoFull=1 is discarded. fifoFull stays high, and the discarded value never appears on serOut.
- R4: convClk is taken through three fast flops, and the block advances exactly one serial step per convClk rising edge. serOut changes on the third fast edge after the first fast edge that sees convClk high. Holding convClk high, or taking it low, causes no further step.
- R5: Each sample goes out as 8 consecutive serial steps, most significant bit first (bit 7 on the first step, bit 0 on the eighth).
- R6: wordStrobe is 1 during the first bit of each sample and 0 during the other seven bits.
- R7: The step after a sample's eighth bit takes the next queued sample, with no gap. Taking a sample frees one queue slot, so fifoFull drops after the first sample of a full queue is taken.
- R8: If the queue is empty when a new sample is needed, the previous sample is sent again and underrun becomes 1. It stays 1 until reset, even after new samples arrive.
- R9: A reset in the middle of a sample clears the bit position and the queue. The first step after reset starts a fresh sample taken from newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe for one sample |
| wrData | input | 8 | Sample written by the host |
| convClk | input | 1 | Asynchronous converter bit clock, sampled as data |
| serOut | output | 1 | Serial data to the converter |
| wordStrobe | output | 1 | High during the first bit of each sample |
| fifoFull | output | 1 | Queue has no free slot |
| fifoEmpty | output | 1 | Queue holds no sample |
| underrun | output | 1 | Sticky flag: a sample was needed while the queue was empty |

## Verification
The hardest case to reach is the latency and single-step behaviour of the synchroniser path. The stimulus changes convClk one nanosecond after a fast edge, so the capture edge is known exactly. It then samples serOut one edge before and one edge after the expected update, and holds convClk high and then low for forty cycles to show that neither level adds a step. The underrun case is reached by draining a full queue completely, which also shows that the discarded write never came out.

// File: rtl/dac_drv_pkg.sv
package dac_drv_pkg;

  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic loadNew;     // load a fresh sample from the queue (and pop it)
    logic loadRepeat;  // queue empty: reload the previously sent sample
    logic shiftBit;    // move to the next bit of the current sample
  } dacStrobe_t;

endpackage

// File: rtl/dac_drv_fifo.sv
module dac_drv_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              popEn,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wrPtr, rdPtr;
  logic              acceptWr, acceptRd;

  assign empty    = (wrPtr == rdPtr);
  assign full     = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign acceptWr = wrEn && !full;
  assign acceptRd = popEn && !empty;
  assign rdData   = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (acceptWr) mem[wrPtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (acceptWr) wrPtr <= wrPtr + 1'b1;
      if (acceptRd) rdPtr <= rdPtr + 1'b1;
    end
  end

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && !popEn) |=> full);

  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R8
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    empty |=> (rdPtr == $past(rdPtr)));

endmodule

// File: rtl/dac_drv_edge_sync.sv
module dac_drv_edge_sync #(
  parameter int SYNC_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic tick
);
  logic [SYNC_LEN-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[SYNC_LEN-2:0], asyncIn};
  end

  // Rising edge seen between the last two stages.
  assign tick = stage[SYNC_LEN-2] && !stage[SYNC_LEN-1];

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/dac_drv_ctrl.sv
module dac_drv_ctrl
  import dac_drv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fifoEmpty,
  output dacStrobe_t strobe,
  output logic       underrun
);
  localparam int          CW   = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0] bitCnt;
  logic          needWord;

  assign needWord          = tick && (bitCnt == '0);
  assign strobe.loadNew    = needWord && !fifoEmpty;
  assign strobe.loadRepeat = needWord && fifoEmpty;
  assign strobe.shiftBit   = tick && (bitCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      underrun <= 1'b0;
    end else begin
      if (tick) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      if (strobe.loadRepeat) underrun <= 1'b1;
    end
  end

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R4
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadNew || strobe.loadRepeat || strobe.shiftBit) |-> tick);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.loadNew, strobe.loadRepeat, strobe.shiftBit}));

endmodule

// File: rtl/dac_drv_datapath.sv
module dac_drv_datapath
  import dac_drv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dacStrobe_t        strobe,
  input  logic [DATA_W-1:0] fifoData,
  output logic              serOut,
  output logic              wordStrobe
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lastSample;
  logic              anyStep;

  assign anyStep = strobe.loadNew || strobe.loadRepeat || strobe.shiftBit;
  assign serOut  = shiftReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg   <= '0;
      lastSample <= '0;
      wordStrobe <= 1'b0;
    end else begin
      if (strobe.loadNew) begin
        shiftReg   <= fifoData;
        lastSample <= fifoData;
      end else if (strobe.loadRepeat) begin
        shiftReg   <= lastSample;
      end else if (strobe.shiftBit) begin
        shiftReg   <= {shiftReg[DATA_W-2:0], 1'b0};
      end
      if (anyStep) wordStrobe <= strobe.loadNew || strobe.loadRepeat;
    end
  end

  // R4
  ser_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !anyStep |=> $stable(serOut));

  // R6
  strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wordStrobe) |-> $past(strobe.loadNew || strobe.loadRepeat));

endmodule

// File: rtl/dac_stream_driver.sv
module dac_stream_driver
  import dac_drv_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int SYNC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              convClk,
  output logic              serOut,
  output logic              wordStrobe,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              underrun
);
  logic              tick;
  dacStrobe_t        strobe;
  logic [DATA_W-1:0] fifoData;

  dac_drv_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .popEn(strobe.loadNew), .rdData(fifoData),
    .full(fifoFull), .empty(fifoEmpty)
  );

  dac_drv_edge_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(convClk), .tick(tick)
  );

  dac_drv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .fifoEmpty(fifoEmpty),
    .strobe(strobe), .underrun(underrun)
  );

  dac_drv_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fifoData(fifoData),
    .serOut(serOut), .wordStrobe(wordStrobe)
  );

endmodule

// File: tb/dac_stream_driver_tb.sv
`timescale 1ns/1ps
module dac_stream_driver_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       convClk = 1'b0;
  logic       serOut, wordStrobe, fifoFull, fifoEmpty, underrun;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dac_stream_driver u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .convClk(convClk),
    .serOut(serOut), .wordStrobe(wordStrobe), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .underrun(underrun)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1 rst = 1'b1; convClk = 1'b0; wrEn = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic writeSample(input logic [7:0] v);
    @(posedge clk); #1 wrEn = 1'b1; wrData = v;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  // One slow period: 10 fast cycles high, 10 low; sampled in the low phase.
  task automatic slowTick();
    @(posedge clk); #1 convClk = 1'b1;
    repeat (10) @(posedge clk);
    #1 convClk = 1'b0;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic readWord(input logic [7:0] exp, input string req);
    for (int i = 0; i < 8; i++) begin
      slowTick();
      check({req, " R5 bit"}, serOut, exp[7-i]);
      check({req, " R6 strobe"}, wordStrobe, (i == 0));
    end
  endtask

  task automatic testReset();
    doReset();
    check("R1 empty", fifoEmpty, 1);
    check("R1 full", fifoFull, 0);
    check("R1 serOut", serOut, 0);
    check("R1 wordStrobe", wordStrobe, 0);
    check("R1 underrun", underrun, 0);
  endtask

  task automatic testFillDrain();
    logic [7:0] v;
    doReset();
    for (int i = 0; i < 16; i++) begin
      v = 8'(i * 29 + 3);
      writeSample(v);
      if (i == 0) check("R2 empty drop", fifoEmpty, 0);
      if (i == 14) check("R2 not yet full", fifoFull, 0);
    end
    check("R2 full at 16", fifoFull, 1);
    writeSample(8'hEE);
    check("R3 full after ignored write", fifoFull, 1);
    for (int i = 0; i < 16; i++) begin
      v = 8'(i * 29 + 3);
      readWord(v, "R7 stream");
      if (i == 0) check("R7 full drops after pop", fifoFull, 0);
    end
    check("R7 empty after drain", fifoEmpty, 1);
    check("R8 no underrun yet", underrun, 0);
    v = 8'(15 * 29 + 3);
    readWord(v, "R3 R8 repeat");
    check("R8 underrun set", underrun, 1);
    writeSample(8'h5A);
    readWord(8'h5A, "R8 new after underrun");
    check("R8 underrun sticky", underrun, 1);
  endtask

  task automatic testEdgeTiming();
    doReset();
    writeSample(8'hA5);
    slowTick();
    check("R4 first bit", serOut, 1);
    // next bit (bit 6) is 0, then bit 5 is 1
    @(posedge clk); #1 convClk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R4 not yet stepped", serOut, 1);
    @(posedge clk); #1;
    check("R4 stepped on third edge", serOut, 0);
    repeat (40) @(posedge clk); #1;
    check("R4 high level no step", serOut, 0);
    convClk = 1'b0;
    repeat (40) @(posedge clk); #1;
    check("R4 falling edge no step", serOut, 0);
    slowTick();
    check("R4 next rise steps", serOut, 1);
  endtask

  task automatic testMidReset();
    doReset();
    writeSample(8'hC3);
    slowTick(); slowTick(); slowTick();
    doReset();
    check("R9 empty after reset", fifoEmpty, 1);
    writeSample(8'h3C);
    readWord(8'h3C, "R9 restart");
    check("R9 underrun clear", underrun, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    testReset();
    testFillDrain();
    testEdgeTiming();
    testMidReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule